// File: doc/BRIEF.md
# Moving-Inversions Memory Self-Test Engine

This block is a built-in self-test controller for a synchronous single-port memory of 4096 words of 12 bits. On the first clock edge after the active-low reset is released it samples a front-panel examine key. If the key is held, the engine takes over the memory port and runs the moving-inversions test until the next reset. If the key is not held, the engine stays idle and leaves the port quiet.

Each pass has three phases. First it fills every word with a background pattern in ascending order. Next it climbs the address range, reading each word, expecting the pattern and writing back its complement. Last it descends from the top address to zero, reading each word, expecting the complement and restoring the pattern. The background is a single set bit that rotates one place left after every pass.

Read data arrives one cycle after the read request. It is compared with an expected word that was registered when the read was issued. The first mismatch raises a sticky fail flag and freezes the failing address, the expected word and the word actually read. A pass counter advances each time a full pass ends.

Top module: `mi_bist`

## Requirements
- R1: On the first rising clock edge after rst_ni rises, the engine samples examine_i. If it is 0, active_o, mem_we_o and mem_re_o stay 0 until the next reset, whatever examine_i does later. If it is 1, active_o becomes 1 and stays 1 until reset.
- R2: The fill phase starts in the cycle after that first edge. It lasts 4096 cycles. In each cycle mem_we_o=1, mem_re_o=0, and mem_addr_o steps 0,1,…,4095 with mem_wdata_o equal to the background pattern P.
- R3: The ascending phase follows the fill. For each address a from 0 to 4095 there is a read cycle (mem_re_o=1, mem_we_o=0, mem_addr_o=a), then a write cycle (mem_we_o=1, mem_addr_o=a, mem_wdata_o=~P).
- R4: The descending phase follows. For each address a from 4095 down to 0 there is a read cycle at a, then a write cycle at a with mem_wdata_o=P. After the write at address 0, the next fill phase begins.
- R5: mem_rdata_i is taken one cycle after the read request, in the write cycle. It is compared with P in the ascending phase and with ~P in the descending phase.
- R6: On the first mismatch, fail_o goes to 1 and fail_addr_o, fail_exp_o and fail_got_o record the address, the expected word and the word read. These values are held until reset, and later mismatches do not change them.
- R7: pass_cnt_o starts at 0 and increases by exactly one at the clock edge that ends each pass. One pass is 5×4096 cycles.
- R8: The pattern is 12'h001 in the first pass and rotates left by one bit in each following pass. For example, the second pass uses 12'h002.
- R9: mem_we_o and mem_re_o are never both 1. The address and data sequence continues unchanged after a failure has been recorded.
- R10: While rst_ni is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| examine_i | input | 1 | Examine key, sampled on the first edge after reset |
| mem_addr_o | output | 12 | Memory address |
| mem_wdata_o | output | 12 | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_rdata_i | input | 12 | Memory read data, one-cycle latency |
| active_o | output | 1 | Test mode running |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | 12 | Address of the first mismatch |
| fail_exp_o | output | 12 | Expected word at the first mismatch |
| fail_got_o | output | 12 | Word read at the first mismatch |
| pass_cnt_o | output | 8 | Completed pass count |

## Verification
The hardest coincidence is the read-back check at address 0 in the descending phase. That comparison falls on the same edge where the pass counter advances and the background pattern rotates. To provoke it, the memory model holds bit 0 stuck at 1 at address 0, so the only mismatch is the last compare of the pass. The engine must then report the old complement 12'hFFE as expected and 12'hFFF as read, not a value built from the rotated pattern, and the pass count must still step to one. A second case runs two passes with a fault that mismatches in both passes, which shows that the first capture is never overwritten.

// File: rtl/mi_bist_pkg.sv
package mi_bist_pkg;
  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_FILL,
    ST_UP_RD,
    ST_UP_WR,
    ST_DN_RD,
    ST_DN_WR
  } bist_st_e;
endpackage

// File: rtl/mi_bist_seq.sv
module mi_bist_seq
  import mi_bist_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              examine_i,
  output bist_st_e          st_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pass_end_o
);
  localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

  bist_st_e          st_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_BOOT;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        ST_BOOT: begin
          st_q   <= examine_i ? ST_FILL : ST_IDLE;
          addr_q <= '0;
        end
        ST_IDLE: st_q <= ST_IDLE;
        ST_FILL: begin
          if (addr_q == ADDR_TOP) begin
            st_q   <= ST_UP_RD;
            addr_q <= '0;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_UP_RD: st_q <= ST_UP_WR;
        ST_UP_WR: begin
          st_q <= (addr_q == ADDR_TOP) ? ST_DN_RD : ST_UP_RD;
          if (addr_q != ADDR_TOP) addr_q <= addr_q + 1'b1;
        end
        ST_DN_RD: st_q <= ST_DN_WR;
        ST_DN_WR: begin
          st_q <= (addr_q == '0) ? ST_FILL : ST_DN_RD;
          if (addr_q != '0) addr_q <= addr_q - 1'b1;
        end
        default: st_q <= ST_BOOT;
      endcase
    end
  end

  assign st_o       = st_q;
  assign addr_o     = addr_q;
  assign pass_end_o = (st_q == ST_DN_WR) && (addr_q == '0);
endmodule

// File: rtl/mi_bist_pat.sv
module mi_bist_pat #(
  parameter int              DATA_W = 12,
  parameter logic [DATA_W-1:0] SEED = 12'h001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [DATA_W-1:0] pat_o
);
  logic [DATA_W-1:0] pat_q;

  generate
    if (DATA_W > 1) begin : g_rot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pat_q <= SEED;
        else if (step_i) pat_q <= {pat_q[DATA_W-2:0], pat_q[DATA_W-1]};
      end
    end else begin : g_flip
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pat_q <= SEED;
        else if (step_i) pat_q <= ~pat_q;
      end
    end
  endgenerate

  assign pat_o = pat_q;
endmodule

// File: rtl/mi_bist_cmp.sv
module mi_bist_cmp #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] rd_exp_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_got_o
);
  logic              chk_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;
  logic              miss;

  // snapshot of the request, aligned with the returning data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_q  <= 1'b0;
      addr_q <= '0;
      exp_q  <= '0;
    end else begin
      chk_q <= rd_req_i;
      if (rd_req_i) begin
        addr_q <= rd_addr_i;
        exp_q  <= rd_exp_i;
      end
    end
  end

  assign miss = chk_q && (rdata_i != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o      <= 1'b0;
      fail_addr_o <= '0;
      fail_exp_o  <= '0;
      fail_got_o  <= '0;
    end else if (miss && !fail_o) begin
      fail_o      <= 1'b1;
      fail_addr_o <= addr_q;
      fail_exp_o  <= exp_q;
      fail_got_o  <= rdata_i;
    end
  end
endmodule

// File: rtl/mi_bist.sv
module mi_bist
  import mi_bist_pkg::*;
#(
  parameter int                ADDR_W = 12,
  parameter int                DATA_W = 12,
  parameter int                PASS_W = 8,
  parameter logic [DATA_W-1:0] SEED   = 12'h001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              examine_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              active_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_got_o,
  output logic [PASS_W-1:0] pass_cnt_o
);
  bist_st_e          st;
  logic [ADDR_W-1:0] addr;
  logic              pass_end;
  logic [DATA_W-1:0] pat;
  logic [DATA_W-1:0] rd_exp;
  logic [PASS_W-1:0] pass_q;

  mi_bist_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .examine_i (examine_i),
    .st_o      (st),
    .addr_o    (addr),
    .pass_end_o(pass_end)
  );

  mi_bist_pat #(.DATA_W(DATA_W), .SEED(SEED)) u_pat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(pass_end),
    .pat_o (pat)
  );

  always_comb begin
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    mem_wdata_o = '0;
    rd_exp      = ~pat;
    unique case (st)
      ST_FILL:  begin mem_we_o = 1'b1; mem_wdata_o = pat;  end
      ST_UP_RD: begin mem_re_o = 1'b1; rd_exp      = pat;  end
      ST_UP_WR: begin mem_we_o = 1'b1; mem_wdata_o = ~pat; end
      ST_DN_RD: begin mem_re_o = 1'b1; rd_exp      = ~pat; end
      ST_DN_WR: begin mem_we_o = 1'b1; mem_wdata_o = pat;  end
      default:  ;
    endcase
  end

  assign mem_addr_o = addr;
  assign active_o   = (st != ST_BOOT) && (st != ST_IDLE);

  mi_bist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_req_i   (mem_re_o),
    .rd_addr_i  (addr),
    .rd_exp_i   (rd_exp),
    .rdata_i    (mem_rdata_i),
    .fail_o     (fail_o),
    .fail_addr_o(fail_addr_o),
    .fail_exp_o (fail_exp_o),
    .fail_got_o (fail_got_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pass_q <= '0;
    else if (pass_end) pass_q <= pass_q + 1'b1;
  end

  assign pass_cnt_o = pass_q;
endmodule

// File: rtl/mi_bist_chk.sv
module mi_bist_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12,
  parameter int PASS_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              examine_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic              active_o,
  input logic              fail_o,
  input logic [ADDR_W-1:0] fail_addr_o,
  input logic [DATA_W-1:0] fail_exp_o,
  input logic [DATA_W-1:0] fail_got_o,
  input logic [PASS_W-1:0] pass_cnt_o
);
  // R9
  no_rw_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));

  // R1
  quiet_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (!mem_we_o && !mem_re_o));

  // R1
  active_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |=> active_o);

  // R3
  read_then_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> (mem_we_o && mem_addr_o == $past(mem_addr_o)));

  // R6
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> fail_o);

  // R6
  fail_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> ($stable(fail_addr_o) && $stable(fail_exp_o) && $stable(fail_got_o)));

  // R7
  pass_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pass_cnt_o) |-> (pass_cnt_o == PASS_W'($past(pass_cnt_o) + 1'b1)));

  // R7
  pass_only_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> (pass_cnt_o == '0));
endmodule

bind mi_bist mi_bist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PASS_W(PASS_W)) u_chk (.*);

// File: tb/tb_mi_bist.sv
`timescale 1ns/1ps
module tb_mi_bist;
  localparam int AW = 12;
  localparam int DW = 12;
  localparam int PW = 8;
  localparam int N  = 1 << AW;

  typedef struct packed {
    logic        exam;
    logic        flt;
    logic [11:0] fa;
    logic [3:0]  fb;
    logic [1:0]  passes;
    logic        efail;
    logic [11:0] eaddr;
    logic [11:0] eexp;
    logic [11:0] egot;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 12'h000, 4'd0,  2'd0, 1'b0, 12'h000, 12'h000, 12'h000},
    '{1'b1, 1'b1, 12'h8FF, 4'd5,  2'd2, 1'b1, 12'h8FF, 12'h001, 12'h021},
    '{1'b1, 1'b0, 12'h000, 4'd0,  2'd1, 1'b0, 12'h000, 12'h000, 12'h000},
    '{1'b1, 1'b1, 12'h000, 4'd0,  2'd1, 1'b1, 12'h000, 12'hFFE, 12'hFFF},
    '{1'b1, 1'b1, 12'hFFF, 4'd11, 2'd1, 1'b1, 12'hFFF, 12'h001, 12'h801}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          examine_i = 1'b0;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_we_o, mem_re_o;
  logic [DW-1:0] mem_rdata_i;
  logic          active_o, fail_o;
  logic [AW-1:0] fail_addr_o;
  logic [DW-1:0] fail_exp_o, fail_got_o;
  logic [PW-1:0] pass_cnt_o;

  logic          flt_en = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic [3:0]    flt_bit = '0;
  logic [DW-1:0] ram [N];

  int checks = 0;
  int errors = 0;
  int smm = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  mi_bist dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .examine_i(examine_i),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i),
    .active_o(active_o), .fail_o(fail_o), .fail_addr_o(fail_addr_o),
    .fail_exp_o(fail_exp_o), .fail_got_o(fail_got_o), .pass_cnt_o(pass_cnt_o)
  );

  // synchronous RAM with an optional stuck-at-1 bit on the read path
  always_ff @(posedge clk_i) begin
    if (mem_we_o) ram[mem_addr_o] <= mem_wdata_o;
    if (mem_re_o)
      mem_rdata_i <= ram[mem_addr_o] |
        ((flt_en && mem_addr_o == flt_addr) ? (DW'(1) << flt_bit) : DW'(0));
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic re, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk_i);
    @(negedge clk_i);
    if (mem_we_o !== we || mem_re_o !== re || mem_addr_o !== a || (we && mem_wdata_o !== d)) begin
      if (smm == 0)
        $display("stream mismatch t=%0t we %b/%b re %b/%b addr %h/%h data %h/%h",
                 $time, mem_we_o, we, mem_re_o, re, mem_addr_o, a, mem_wdata_o, d);
      smm++;
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [DW-1:0] p;
    @(negedge clk_i);
    rst_ni    = 1'b0;
    #1;
    // R10 reset clears outputs asynchronously
    chk("R10 reset outputs",
        {20'd0, mem_we_o, mem_re_o, active_o, fail_o, pass_cnt_o},
        32'd0);
    chk("R10 reset addr", {20'd0, mem_addr_o}, 32'd0);
    examine_i = v.exam;
    flt_en    = v.flt;
    flt_addr  = v.fa;
    flt_bit   = v.fb;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    smm    = 0;
    if (!v.exam) begin
      // R1: key raised after the sampling edge must not start the test
      @(posedge clk_i);
      @(negedge clk_i);
      examine_i = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk_i);
        if (active_o || mem_we_o || mem_re_o) smm++;
      end
      chk("R1 idle port quiet", smm, 0);
      chk("R1 idle no pass/fail", {23'd0, fail_o, pass_cnt_o}, 32'd0);
      examine_i = 1'b0;
      return;
    end
    p = 12'h001;
    for (int ps = 0; ps < int'(v.passes); ps++) begin
      for (int a = 0; a < N; a++) begin
        cyc(1'b1, 1'b0, AW'(a), p);
        // R7 counter value at start of each pass; R1 active seen
        if (a == 0) begin
          chk("R7 pass count at pass start", {24'd0, pass_cnt_o}, ps);
          chk("R1 active after examine", {31'd0, active_o}, 32'd1);
        end
      end
      for (int a = 0; a < N; a++) begin
        cyc(1'b0, 1'b1, AW'(a), '0);
        cyc(1'b1, 1'b0, AW'(a), ~p);
      end
      for (int a = N - 1; a >= 0; a--) begin
        cyc(1'b0, 1'b1, AW'(a), '0);
        cyc(1'b1, 1'b0, AW'(a), p);
      end
      p = {p[DW-2:0], p[DW-1]};
    end
    @(posedge clk_i);
    @(negedge clk_i);
    // stream covers R2 R3 R4 R8 R9 (sequence keeps going after a failure)
    chk("R2 R3 R4 R8 R9 stream mismatches", smm, 0);
    chk("R7 pass count after run", {24'd0, pass_cnt_o}, {30'd0, v.passes});
    // R5 R6 capture contents
    chk("R6 fail flag", {31'd0, fail_o}, {31'd0, v.efail});
    if (v.efail) begin
      chk("R6 fail addr", {20'd0, fail_addr_o}, {20'd0, v.eaddr});
      chk("R5 fail expected word", {20'd0, fail_exp_o}, {20'd0, v.eexp});
      chk("R5 fail read word", {20'd0, fail_got_o}, {20'd0, v.egot});
    end
  endtask

  initial begin
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);
    // R10 mid-run reset, then R1 idle restart with key low
    @(negedge clk_i);
    rst_ni    = 1'b0;
    examine_i = 1'b0;
    #1;
    chk("R10 reset during run", {29'd0, mem_we_o, mem_re_o, active_o}, 32'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R1 no entry with key low", {29'd0, mem_we_o, mem_re_o, active_o}, 32'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got hung exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule